// File: doc/BRIEF.md
# Multichannel PCM Audio Transmitter

This block takes two's-complement PCM samples from a small write-side FIFO and sends them, one bit per bit-clock period, on a serial data line. It generates its own bit clock from the system clock and its own word clock, which marks the left and right sample slots. One frame carries one, two or three left/right channel pairs in a row, and the index of the pair on the line is brought out so that a downstream codec or multiplexer can follow it.

The configuration inputs are static while the block is enabled. They select the channel-pair count, the bit order, a one-bit data delay for I2S timing, a toggling or single-pulse word clock, and the sample width. A width of 16 bits packs two samples into each FIFO word. Wider samples, from 17 to 24 bits, take one word each. The block raises a service interrupt while the FIFO has room, and an error interrupt from a sticky flag. Underflow and overflow both set that flag.

The serializer is a three-state machine. IDLE is the reset state and the state while `enable` is low. In IDLE the block drives nothing and takes nothing from the FIFO. The transition *start* (IDLE to LEFT) happens on the first bit-clock falling edge after `enable` rises. LEFT sends a left slot. The transition *left_done* (LEFT to RIGHT) fires after the last bit of the slot. RIGHT sends a right slot. The transition *right_done* (RIGHT to LEFT) fires after its last bit and advances the pair index, wrapping to 0 after the last pair. The transition *stop* (any state to IDLE) is taken in the clock cycle after `enable` is seen low.

Top module: `pcm_audio_tx`

## Requirements
- R1: While `enable` is high, `bclk` toggles every BCLK_HALF system clocks, so one bit period lasts 2·BCLK_HALF clocks. While `enable` is low, `bclk` is held low.
- R2: Every slot lasts SLOT_BITS bit periods. Slots alternate left then right, and `chan_pair` holds the index of the current pair for the whole slot. The index counts 0 up to N−1 and then wraps to 0. N comes from `chan_sel`: 00 gives 1, 01 gives 2, 10 gives 3, and the reserved code 11 gives 1.
- R3: With `pulse_mode`=0, `wclk` is 0 for the whole of every left slot and 1 for the whole of every right slot.
- R4: With `pulse_mode`=1, `wclk` is 1 only during the first bit period of each left slot, and 0 at all other times.
- R5: With `lsb_first`=0 the sample is sent MSB first. With `lsb_first`=1 it is sent LSB first. The bit periods of a slot after the sample's last bit carry 0.
- R6: With `data_delay`=1 the first bit period of each slot carries 0, and the sample begins in the second bit period. With `data_delay`=0 the sample begins in the first bit period.
- R7: The effective width W is taken from `samp_bits`. Values of 16 or less give 16, values of 24 or more give 24, and other values are used as given. For 17 ≤ W ≤ 24, each slot consumes one FIFO word, the sample is bits [W−1:0] of that word, and the higher bits are ignored.
- R8: With W = 16, each pair consumes one FIFO word. Bits [31:16] are the left sample and bits [15:0] are the right sample.
- R9: `sdata`, `wclk` and `chan_pair` change only in the clock cycle in which `bclk` falls, as long as `enable` stays high.
- R10: If a slot needs a word while the FIFO is empty, the slot sends all zeros and the error flag is set. For a packed pair, both of its slots send zeros.
- R11: A write while the FIFO holds FIFO_DEPTH words is discarded and sets the error flag. The stored words are then sent unchanged and in order.
- R12: `err_irq` equals `err_irq_en` AND the sticky error flag. `err_clr` clears the flag. An underflow or overflow in the same cycle wins over the clear.
- R13: `svc_irq` equals `svc_irq_en` AND "the FIFO holds fewer than FIFO_DEPTH words".
- R14: After reset, `bclk`, `wclk`, `sdata`, `chan_pair` and `err_irq` are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the bit clock and the serializer |
| chan_sel | input | 2 | Channel-pair count code |
| pulse_mode | input | 1 | 1 selects a one-bit word-clock pulse per pair |
| lsb_first | input | 1 | 1 sends the LSB first |
| data_delay | input | 1 | 1 delays the data by one bit period (I2S timing) |
| samp_bits | input | 5 | Sample width request (clamped to 16..24) |
| svc_irq_en | input | 1 | Service interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Clears the sticky error flag |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock |
| sdata | output | 1 | Serial data |
| chan_pair | output | 2 | Index of the pair on the line |
| svc_irq | output | 1 | Service interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
A wrong slot position or state in the serializer appears on `sdata` within one bit period, as a bit in the wrong place, a missing delay bit, or bits beyond W that are not zero. It also shows as a `wclk` that does not line up with the slot boundaries. A wrong pair counter shows up on `chan_pair` at the very next slot boundary. Read-pointer or packing errors show up as samples sent in the wrong order or halves swapped, and they appear within the first pair. Each check compares a whole 32-bit slot against a model of the requirements. A wrong FIFO occupancy shows at once on `svc_irq` and on the error flag when the FIFO fills.

// File: rtl/pcm_audio_tx_pkg.sv
package pcm_audio_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    // Pairs per frame; the reserved code behaves as a single pair.
    function automatic logic [1:0] pairs_from_code(input logic [1:0] code);
        unique case (code)
            2'b01:   return 2'd2;
            2'b10:   return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    // Effective sample width, limited to 16..24.
    function automatic logic [4:0] clamp_width(input logic [4:0] req);
        if (req <= 5'd16)      return 5'd16;
        else if (req >= 5'd24) return 5'd24;
        else                   return req;
    endfunction

endpackage

// File: rtl/pcm_tx_bitclk.sv
module pcm_tx_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick     = (cnt == CW'(HALF - 1));
    assign fall_evt = en & tick & bclk;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + CW'(1);
        end
    end

    // R1
    bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bclk);

endmodule

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign do_push  = push & ~full;
    assign do_pop   = pop & ~empty;
    assign overflow = push & full;
    assign head     = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R11
    fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    // R10
    fifo_dry_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/pcm_tx_serial.sv
module pcm_tx_serial
    import pcm_audio_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        fall_evt,
    input  logic [1:0]  chan_sel,
    input  logic        pulse_mode,
    input  logic        lsb_first,
    input  logic        data_delay,
    input  logic [4:0]  samp_bits,
    input  logic [31:0] head,
    input  logic        empty,
    output logic        pop,
    output logic        underflow,
    output logic        sdata,
    output logic        wclk,
    output logic [1:0]  chan_pair
);
    localparam int PW   = $clog2(SLOT_BITS);
    localparam int IW   = PW + 1;
    localparam int CURW = 1 << IW;

    tx_state_e       state, st_n;
    logic [PW-1:0]   bitpos, pos_n;
    logic [1:0]      pair, pair_n, npairs;
    logic [CURW-1:0] cur, cur_n;
    logic [15:0]     hold, hold_n;
    logic [4:0]      wid;
    logic            packed_md, slot_end, need, to_right_pk;
    logic [31:0]     word;

    assign npairs    = pairs_from_code(chan_sel);
    assign wid       = clamp_width(samp_bits);
    assign packed_md = (wid == 5'd16);
    assign slot_end  = (bitpos == PW'(SLOT_BITS - 1));
    assign word      = empty ? 32'd0 : head;
    assign pop       = need & ~empty;
    assign underflow = need & empty;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitpos <= '0;
            pair   <= '0;
            cur    <= '0;
            hold   <= '0;
        end else begin
            state  <= st_n;
            bitpos <= pos_n;
            pair   <= pair_n;
            cur    <= cur_n;
            hold   <= hold_n;
        end
    end

    // Next state and sample fetch
    always_comb begin
        st_n        = state;
        pos_n       = bitpos;
        pair_n      = pair;
        need        = 1'b0;
        to_right_pk = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall_evt) begin
                    st_n   = ST_LEFT;
                    pos_n  = '0;
                    pair_n = '0;
                    need   = 1'b1;
                end
            end
            ST_LEFT: begin
                if (fall_evt) begin
                    if (slot_end) begin
                        st_n        = ST_RIGHT;
                        pos_n       = '0;
                        need        = ~packed_md;
                        to_right_pk = packed_md;
                    end else begin
                        pos_n = bitpos + PW'(1);
                    end
                end
            end
            ST_RIGHT: begin
                if (fall_evt) begin
                    if (slot_end) begin
                        st_n   = ST_LEFT;
                        pos_n  = '0;
                        pair_n = (pair >= npairs - 2'd1) ? 2'd0 : pair + 2'd1;
                        need   = 1'b1;
                    end else begin
                        pos_n = bitpos + PW'(1);
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (!en) begin
            st_n        = ST_IDLE;
            pos_n       = '0;
            pair_n      = '0;
            need        = 1'b0;
            to_right_pk = 1'b0;
        end

        cur_n  = cur;
        hold_n = hold;
        if (need) begin
            if (packed_md) begin
                cur_n  = CURW'(word[31:16]);
                hold_n = word[15:0];
            end else begin
                cur_n  = CURW'(word[23:0]);
            end
        end else if (to_right_pk) begin
            cur_n = CURW'(hold);
        end
    end

    // Outputs
    logic [IW-1:0] pos_w, idx_w, wid_w, sel_w;
    logic          in_rng;

    always_comb begin
        pos_w  = IW'(bitpos);
        idx_w  = pos_w - IW'(data_delay);
        wid_w  = IW'(wid);
        in_rng = (state != ST_IDLE) && (pos_w >= IW'(data_delay)) && (idx_w < wid_w);
        sel_w  = lsb_first ? idx_w : (wid_w - IW'(1) - idx_w);
        sdata  = in_rng ? cur[sel_w] : 1'b0;
        if (pulse_mode) wclk = (state == ST_LEFT) && (bitpos == '0);
        else            wclk = (state == ST_RIGHT);
        chan_pair = pair;
    end

    // R9
    line_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fall_evt) |=> ($stable(sdata) && $stable(wclk) && $stable(chan_pair)));
    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pulse_mode && wclk && fall_evt) |=> !wclk);
    // R2
    pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (chan_pair < npairs));
    // R10
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cur == '0));

endmodule

// File: rtl/pcm_audio_tx.sv
module pcm_audio_tx #(
    parameter int BCLK_HALF  = 2,
    parameter int SLOT_BITS  = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [1:0]  chan_sel,
    input  logic        pulse_mode,
    input  logic        lsb_first,
    input  logic        data_delay,
    input  logic [4:0]  samp_bits,
    input  logic        svc_irq_en,
    input  logic        err_irq_en,
    input  logic        err_clr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        bclk,
    output logic        wclk,
    output logic        sdata,
    output logic [1:0]  chan_pair,
    output logic        svc_irq,
    output logic        err_irq
);
    logic        fall_evt, pop, underflow, overflow, empty, full, err_flag;
    logic [31:0] head;

    pcm_tx_bitclk #(.HALF(BCLK_HALF)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .bclk     (bclk),
        .fall_evt (fall_evt)
    );

    pcm_tx_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .overflow  (overflow)
    );

    pcm_tx_serial #(.SLOT_BITS(SLOT_BITS)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .fall_evt   (fall_evt),
        .chan_sel   (chan_sel),
        .pulse_mode (pulse_mode),
        .lsb_first  (lsb_first),
        .data_delay (data_delay),
        .samp_bits  (samp_bits),
        .head       (head),
        .empty      (empty),
        .pop        (pop),
        .underflow  (underflow),
        .sdata      (sdata),
        .wclk       (wclk),
        .chan_pair  (chan_pair)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                     err_flag <= 1'b0;
        else if (overflow || underflow) err_flag <= 1'b1;
        else if (err_clr)               err_flag <= 1'b0;
    end

    assign svc_irq = svc_irq_en & ~full;
    assign err_irq = err_irq_en & err_flag;

    // R12
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !overflow && !underflow) |=> !err_irq);
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq_en && (overflow || underflow)) |=> (err_irq || !err_irq_en));

endmodule

// File: tb/pcm_audio_tx_test.sv
module pcm_audio_tx_test;
    localparam int HALF  = 2;
    localparam int SLOT  = 32;
    localparam int DEPTH = 8;
    localparam int LOGN  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  chan_sel = 2'b00;
    logic        pulse_mode = 1'b0, lsb_first = 1'b0, data_delay = 1'b0;
    logic [4:0]  samp_bits = 5'd24;
    logic        svc_irq_en = 1'b1, err_irq_en = 1'b1, err_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bclk, wclk, sdata, svc_irq, err_irq;
    logic [1:0]  chan_pair;

    always #4 clk = ~clk;

    pcm_audio_tx #(.BCLK_HALF(HALF), .SLOT_BITS(SLOT), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_sel(chan_sel),
        .pulse_mode(pulse_mode), .lsb_first(lsb_first), .data_delay(data_delay),
        .samp_bits(samp_bits), .svc_irq_en(svc_irq_en), .err_irq_en(err_irq_en),
        .err_clr(err_clr), .wr_en(wr_en), .wr_data(wr_data), .bclk(bclk),
        .wclk(wclk), .sdata(sdata), .chan_pair(chan_pair), .svc_irq(svc_irq),
        .err_irq(err_irq)
    );

    int n_checks = 0, n_err = 0;
    int nbits = 0, cyc = 0, last_rise = -1, period = 0, r9_viol = 0;
    logic       bit_log [LOGN];
    logic       wck_log [LOGN];
    logic [1:0] pr_log  [LOGN];
    logic       bclk_q = 1'b0, en_q = 1'b0;
    logic [3:0] line_q = '0;

    always @(posedge clk) cyc = cyc + 1;

    // Monitor: one record per bit period, taken while bclk is high.
    always @(negedge clk) begin
        if (bclk && !bclk_q) begin
            if (nbits < LOGN) begin
                bit_log[nbits] = sdata;
                wck_log[nbits] = wclk;
                pr_log[nbits]  = chan_pair;
            end
            nbits = nbits + 1;
            if (last_rise >= 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        if (enable && en_q && ({sdata, wclk, chan_pair} != line_q) && !(bclk_q && !bclk))
            r9_viol = r9_viol + 1;
        bclk_q = bclk;
        en_q   = enable;
        line_q = {sdata, wclk, chan_pair};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_slot(input logic [31:0] s, input int w,
                                             input bit lsb, input bit dly);
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < SLOT; k++) begin
            int idx;
            idx = k - int'(dly);
            if (idx >= 0 && idx < w) v[k] = lsb ? s[idx] : s[w-1-idx];
        end
        return v;
    endfunction

    function automatic logic [31:0] got_slot(input int s);
        logic [31:0] v;
        for (int k = 0; k < SLOT; k++) v[k] = bit_log[1 + s*SLOT + k];
        return v;
    endfunction

    function automatic logic [31:0] got_wclk(input int s);
        logic [31:0] v;
        for (int k = 0; k < SLOT; k++) v[k] = wck_log[1 + s*SLOT + k];
        return v;
    endfunction

    function automatic logic [31:0] got_pair(input int s);
        logic [1:0] p0;
        p0 = pr_log[1 + s*SLOT];
        for (int k = 1; k < SLOT; k++)
            if (pr_log[1 + s*SLOT + k] !== p0) return 32'hFFFF_FFFF;
        return {30'd0, p0};
    endfunction

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] cs, input bit pm, input bit lf,
                           input bit dd, input logic [4:0] sb);
        @(posedge clk); #1;
        chan_sel = cs; pulse_mode = pm; lsb_first = lf; data_delay = dd; samp_bits = sb;
    endtask

    task automatic run_slots(input int n);
        @(posedge clk); #1;
        nbits = 0; last_rise = -1; enable = 1'b1;
        while (nbits < 1 + n*SLOT) @(posedge clk);
        #1 enable = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R14 outputs idle", {27'd0, bclk, wclk, sdata, chan_pair, err_irq}, 32'd0);
        chk("R13 svc with empty fifo", {31'd0, svc_irq}, 32'd1);
    endtask

    task automatic t_stereo24();
        logic [31:0] w [4];
        w = '{32'hA512_3456, 32'h5A89_ABCD, 32'hFF80_0001, 32'h007F_FFFE};
        do_reset();
        set_cfg(2'b00, 0, 0, 0, 5'd24);
        for (int i = 0; i < 4; i++) push(w[i]);
        run_slots(4);
        for (int s = 0; s < 4; s++) begin
            chk("R5 R7 msb-first 24-bit data", got_slot(s), exp_slot(w[s] & 32'h00FF_FFFF, 24, 0, 0));
            chk("R3 toggling word clock", got_wclk(s), (s % 2) ? 32'hFFFF_FFFF : 32'h0);
            chk("R2 single pair index", got_pair(s), 32'd0);
        end
        chk("R1 bit period", period, 2*HALF);
        chk("R1 bclk low when disabled", {31'd0, bclk}, 32'd0);
        chk("R10 no underflow when fed", {31'd0, err_irq}, 32'd0);
    endtask

    task automatic t_three_pairs();
        logic [31:0] w [6];
        w = '{32'hABC1_2345, 32'h123F_EDCB, 32'h0008_0001,
              32'hFFF7_FFFE, 32'h5550_F0F0, 32'hAAA0_A5A5};
        do_reset();
        set_cfg(2'b10, 0, 1, 1, 5'd20);
        for (int i = 0; i < 6; i++) push(w[i]);
        run_slots(6);
        for (int s = 0; s < 6; s++) begin
            chk("R5 R6 R7 lsb-first delayed 20-bit", got_slot(s), exp_slot(w[s] & 32'h000F_FFFF, 20, 1, 1));
            chk("R2 three pairs index", got_pair(s), s / 2);
        end
    endtask

    task automatic t_packed_pulse();
        logic [31:0] w [2];
        w = '{32'h8001_7FFE, 32'h1234_ABCD};
        do_reset();
        set_cfg(2'b01, 1, 0, 0, 5'd12);
        for (int i = 0; i < 2; i++) push(w[i]);
        run_slots(4);
        for (int s = 0; s < 4; s++) begin
            logic [31:0] smp;
            smp = (s % 2) ? {16'd0, w[s/2][15:0]} : {16'd0, w[s/2][31:16]};
            chk("R8 R7 packed 16-bit halves", got_slot(s), exp_slot(smp, 16, 0, 0));
            chk("R4 pulsed word clock", got_wclk(s), (s % 2) ? 32'h0 : 32'h1);
            chk("R2 two pairs index", got_pair(s), s / 2);
        end
    endtask

    task automatic t_reserved_code();
        logic [31:0] w [4];
        w = '{32'hFF00_0F0F, 32'h0180_0001, 32'h7E12_3456, 32'h81FE_DCBA};
        do_reset();
        set_cfg(2'b11, 0, 1, 0, 5'd31);
        for (int i = 0; i < 4; i++) push(w[i]);
        run_slots(4);
        for (int s = 0; s < 4; s++) begin
            chk("R7 width above 24 clamps", got_slot(s), exp_slot(w[s] & 32'h00FF_FFFF, 24, 1, 0));
            chk("R2 code 11 acts as one pair", got_pair(s), 32'd0);
        end
    endtask

    task automatic t_underflow();
        do_reset();
        set_cfg(2'b00, 0, 0, 0, 5'd24);
        push(32'h00C3_5A96);
        chk("R12 flag clear before underflow", {31'd0, err_irq}, 32'd0);
        run_slots(3);
        chk("R10 fed slot intact", got_slot(0), exp_slot(32'h00C3_5A96, 24, 0, 0));
        chk("R10 starved slot zero", got_slot(1), 32'd0);
        chk("R10 second starved slot zero", got_slot(2), 32'd0);
        chk("R12 err_irq after underflow", {31'd0, err_irq}, 32'd1);
        @(posedge clk); #1 err_irq_en = 1'b0;
        #1 chk("R12 err_irq masked", {31'd0, err_irq}, 32'd0);
        @(posedge clk); #1 err_irq_en = 1'b1;
        #1 chk("R12 flag is sticky", {31'd0, err_irq}, 32'd1);
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        chk("R12 err_clr clears flag", {31'd0, err_irq}, 32'd0);
    endtask

    task automatic t_overflow();
        logic [31:0] w [9];
        for (int i = 0; i < 9; i++) w[i] = (i * 32'h0011_1111) + 32'h0000_0101;
        do_reset();
        set_cfg(2'b00, 0, 0, 0, 5'd24);
        for (int i = 0; i < DEPTH - 1; i++) push(w[i]);
        chk("R13 svc while room left", {31'd0, svc_irq}, 32'd1);
        push(w[DEPTH-1]);
        chk("R13 svc low when full", {31'd0, svc_irq}, 32'd0);
        chk("R11 no error when just full", {31'd0, err_irq}, 32'd0);
        push(w[DEPTH]);
        chk("R11 overflow sets flag", {31'd0, err_irq}, 32'd1);
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        run_slots(DEPTH + 1);
        for (int s = 0; s < DEPTH; s++)
            chk("R11 stored words unchanged", got_slot(s), exp_slot(w[s] & 32'h00FF_FFFF, 24, 0, 0));
        chk("R10 dropped word never sent", got_slot(DEPTH), 32'd0);
        chk("R10 underflow after drain", {31'd0, err_irq}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_stereo24();
        t_three_pairs();
        t_packed_pulse();
        t_reserved_code();
        t_underflow();
        t_overflow();
        chk("R9 line changes only at bclk fall", r9_viol, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule